// File: doc/BRIEF.md
# ARX Block Function Core

This core computes the block function of a 32-bit add-rotate-xor stream cipher. It takes a 16-word state and a round count, and returns 16 output words. The working state is held as four rows of four words. In every cycle the core mixes all four columns at once with the quarter-round operation. Column rounds and diagonal rounds alternate. A diagonal round is formed by skewing the lanes of rows b, c and d, so that each diagonal lines up as a column. The skew is undone afterwards, and no word ever leaves its row. When the last round is done, the core adds the untouched input copy to the working state one word at a time.

The core is used through one-shot control pins. `start` loads `state_in` and `rounds`. It is accepted only in a cycle where `busy` is low. While a run is in progress `start` is ignored. Nothing can push back on the output: the result appears with a single-cycle `done` pulse, and `state_out` holds that value until the next completion replaces it. A new run may be accepted in the same cycle that `done` is high.

Top module: `arx_block_core`

## Requirements
- R1: Word i of the state sits at bits [32*i+31:32*i] of `state_in` and `state_out`. Words 0-3 form row a, 4-7 row b, 8-11 row c and 12-15 row d. Column j is the set of words j, 4+j, 8+j and 12+j.
- R2: A quarter round on (a,b,c,d) performs these steps in order, with all additions modulo 2^32: a+=b, d^=a, d rotated left 16; c+=d, b^=c, b rotated left 12; a+=b, d^=a, d rotated left 8; c+=d, b^=c, b rotated left 7. The first half of each double round applies it to the four columns.
- R3: The second half of each double round applies the quarter round to the diagonals (0,5,10,15), (1,6,11,12), (2,7,8,13) and (3,4,9,14). It does this by rotating row b left one lane, row c two lanes and row d three lanes, then undoing those rotations.
- R4: An odd round count is treated as the next lower even count. Each double round uses up two rounds.
- R5: A round count of 0 or 1 yields each input word added to itself, modulo 2^32.
- R6: Each output word equals the final working word plus the matching input word, modulo 2^32. With N as the even round count, `done` rises N+2 clock edges after the edge that samples `start`, counting that edge.
- R7: `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R8: While `busy` is high, `start` has no effect: the result and the timing of the run in progress are unchanged, and no extra completion occurs.
- R9: `state_out` changes only in a cycle where `done` is high.
- R10: After reset, `busy`, `done` and `state_out` are all zero.
- R11: A `start` given in the cycle where `done` is high is accepted and begins the next run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; sampled only while busy is low |
| rounds | input | CNT_W | Requested round count (odd values rounded down) |
| state_in | input | 512 | Input state, word i at bits 32*i upward |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse marking a new result |
| state_out | output | 512 | Result words, held until the next completion |

## Verification
Two events can fall in the same cycle: the completion pulse of one run and the acceptance of the next `start`. The bench provokes this by queueing several runs back to back. Each launch waits only until `busy` is low, so it lands on the `done` cycle; this is done with a zero-round run in the middle of the chain. The scoreboard then checks two things. Each result must match the model of the run it belongs to, and each completion must arrive at its own exact latency. A counter also confirms that the overlap really happened.

// File: rtl/arx_pkg.sv
`timescale 1ns/1ps
package arx_pkg;
  localparam int WORD_W  = 32;
  localparam int LANES   = 4;
  localparam int ROWS    = 4;
  localparam int WORDS   = ROWS * LANES;
  localparam int STATE_W = WORDS * WORD_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef word_t [LANES-1:0] row_t;
  typedef row_t  [ROWS-1:0]  grid_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_MIX  = 2'd1,
    PH_SUM  = 2'd2
  } phase_e;

  function automatic word_t rotl(input word_t x, input int unsigned n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction
endpackage

// File: rtl/arx_qround.sv
`timescale 1ns/1ps
// One quarter round on a single column: four add/xor/rotate steps.
module arx_qround
  import arx_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  word_t c_i,
  input  word_t d_i,
  output word_t a_o,
  output word_t b_o,
  output word_t c_o,
  output word_t d_o
);
  word_t a1, b1, c1, d1;
  word_t a2, b2, c2, d2;

  always_comb begin
    a1 = a_i + b_i;
    d1 = rotl(d_i ^ a1, 16);
    c1 = c_i + d1;
    b1 = rotl(b_i ^ c1, 12);
    a2 = a1 + b1;
    d2 = rotl(d1 ^ a2, 8);
    c2 = c1 + d2;
    b2 = rotl(b1 ^ c2, 7);
  end

  assign a_o = a2;
  assign b_o = b2;
  assign c_o = c2;
  assign d_o = d2;
endmodule

// File: rtl/arx_lane_rot.sv
`timescale 1ns/1ps
// Row r is rotated by r lanes; pure wiring. INVERSE undoes the skew.
module arx_lane_rot
  import arx_pkg::*;
#(
  parameter bit INVERSE = 1'b0
)(
  input  grid_t blk_i,
  output grid_t blk_o
);
  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int SHIFT = r % LANES;
        localparam int SRC   = INVERSE ? ((l + LANES - SHIFT) % LANES)
                                       : ((l + SHIFT) % LANES);
        assign blk_o[r][l] = blk_i[r][SRC];
      end
    end
  endgenerate
endmodule

// File: rtl/arx_half_round.sv
`timescale 1ns/1ps
// Half of a double round: column pass, or diagonal pass via lane skew.
module arx_half_round
  import arx_pkg::*;
(
  input  grid_t blk_i,
  input  logic  diag_i,
  output grid_t blk_o
);
  grid_t skewed, mix_in, mixed, unskewed;

  arx_lane_rot #(.INVERSE(1'b0)) u_skew (
    .blk_i (blk_i),
    .blk_o (skewed)
  );

  assign mix_in = diag_i ? skewed : blk_i;

  generate
    for (genvar col = 0; col < LANES; col++) begin : g_col
      word_t qa, qb, qc, qd;
      arx_qround u_qr (
        .a_i (mix_in[0][col]),
        .b_i (mix_in[1][col]),
        .c_i (mix_in[2][col]),
        .d_i (mix_in[3][col]),
        .a_o (qa),
        .b_o (qb),
        .c_o (qc),
        .d_o (qd)
      );
      assign mixed[0][col] = qa;
      assign mixed[1][col] = qb;
      assign mixed[2][col] = qc;
      assign mixed[3][col] = qd;
    end
  endgenerate

  arx_lane_rot #(.INVERSE(1'b1)) u_unskew (
    .blk_i (mixed),
    .blk_o (unskewed)
  );

  assign blk_o = diag_i ? unskewed : mixed;
endmodule

// File: rtl/arx_feedfwd.sv
`timescale 1ns/1ps
// Word-wise modular sum of the mixed state and the saved input.
module arx_feedfwd
  import arx_pkg::*;
(
  input  grid_t work_i,
  input  grid_t orig_i,
  output grid_t sum_o
);
  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign sum_o[r][l] = work_i[r][l] + orig_i[r][l];
      end
    end
  endgenerate
endmodule

// File: rtl/arx_block_core.sv
`timescale 1ns/1ps
module arx_block_core
  import arx_pkg::*;
#(
  parameter int CNT_W = 8
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CNT_W-1:0]   rounds,
  input  logic [STATE_W-1:0] state_in,
  output logic               busy,
  output logic               done,
  output logic [STATE_W-1:0] state_out
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(2);

  phase_e           phase_q;
  grid_t            work_q, orig_q, out_q;
  logic [CNT_W-1:0] left_q;
  logic             diag_q;
  logic             done_q;

  logic [CNT_W-1:0] even_rounds;
  grid_t            half_out, sum_out;
  logic             accept;

  assign even_rounds = {rounds[CNT_W-1:1], 1'b0};
  assign accept      = (phase_q == PH_IDLE) && start;

  arx_half_round u_half (
    .blk_i  (work_q),
    .diag_i (diag_q),
    .blk_o  (half_out)
  );

  arx_feedfwd u_sum (
    .work_i (work_q),
    .orig_i (orig_q),
    .sum_o  (sum_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      work_q  <= '0;
      orig_q  <= '0;
      out_q   <= '0;
      left_q  <= '0;
      diag_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            work_q  <= grid_t'(state_in);
            orig_q  <= grid_t'(state_in);
            left_q  <= even_rounds;
            diag_q  <= 1'b0;
            phase_q <= (even_rounds == '0) ? PH_SUM : PH_MIX;
          end
        end
        PH_MIX: begin
          work_q <= half_out;
          diag_q <= ~diag_q;
          if (diag_q) begin
            left_q <= left_q - STEP;
            if (left_q == STEP) phase_q <= PH_SUM;
          end
        end
        PH_SUM: begin
          out_q   <= sum_out;
          done_q  <= 1'b1;
          phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy      = (phase_q != PH_IDLE);
  assign done      = done_q;
  assign state_out = STATE_W'(out_q);
endmodule

// File: rtl/arx_block_core_chk.sv
`timescale 1ns/1ps
module arx_block_core_chk
  import arx_pkg::*;
#(
  parameter int CNT_W = 8
)(
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [CNT_W-1:0]   rounds,
  input logic               busy,
  input logic               done,
  input logic [STATE_W-1:0] state_out
);
  localparam int LAT_W = CNT_W + 2;

  logic [LAT_W-1:0] run_cycles, want_cycles;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cycles  <= '0;
      want_cycles <= '0;
    end else if (start && !busy) begin
      run_cycles  <= '0;
      want_cycles <= LAT_W'({rounds[CNT_W-1:1], 1'b0}) + LAT_W'(1);
    end else if (busy) begin
      run_cycles <= run_cycles + LAT_W'(1);
    end
  end

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cycles == want_cycles));

  a_r8_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r11_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(state_out));
endmodule

bind arx_block_core arx_block_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .rounds    (rounds),
  .busy      (busy),
  .done      (done),
  .state_out (state_out)
);

// File: tb/test_arx_block_core.sv
`timescale 1ns/1ps
module test_arx_block_core;
  import arx_pkg::*;
  localparam int CNT_W = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic [CNT_W-1:0]   rounds = '0;
  logic [STATE_W-1:0] state_in = '0;
  logic               busy, done;
  logic [STATE_W-1:0] state_out;

  arx_block_core #(.CNT_W(CNT_W)) i_arx_block_core (
    .clk (clk), .rst_n (rst_n), .start (start), .rounds (rounds),
    .state_in (state_in), .busy (busy), .done (done), .state_out (state_out)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [STATE_W-1:0] exp;
    int                 lat;
    int                 c0;
    string              tag;
  } item_t;

  item_t              sb_q[$];
  int                 n_cmp = 0, n_bad = 0, cyc = 0, overlap = 0;
  logic [STATE_W-1:0] last_out = '0;
  bit                 finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %s expected %s", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  // Reference block function using explicit diagonal index sets.
  function automatic logic [STATE_W-1:0] ref_block(input logic [STATE_W-1:0] s, input int nr);
    logic [31:0] x [16];
    logic [31:0] o [16];
    logic [STATE_W-1:0] r;
    for (int i = 0; i < 16; i++) begin
      x[i] = s[32*i +: 32];
      o[i] = x[i];
    end
    for (int k = 0; k < nr / 2; k++) begin
      for (int h = 0; h < 2; h++) begin
        for (int i = 0; i < 4; i++) begin
          int ia, ib, ic, id;
          ia = i;
          ib = 4 + (i + h) % 4;
          ic = 8 + (i + 2*h) % 4;
          id = 12 + (i + 3*h) % 4;
          x[ia] = x[ia] + x[ib]; x[id] = rl(x[id] ^ x[ia], 16);
          x[ic] = x[ic] + x[id]; x[ib] = rl(x[ib] ^ x[ic], 12);
          x[ia] = x[ia] + x[ib]; x[id] = rl(x[id] ^ x[ia], 8);
          x[ic] = x[ic] + x[id]; x[ib] = rl(x[ib] ^ x[ic], 7);
        end
      end
    end
    for (int i = 0; i < 16; i++) r[32*i +: 32] = x[i] + o[i];
    return r;
  endfunction

  function automatic logic [STATE_W-1:0] pattern(input logic [31:0] seed);
    logic [STATE_W-1:0] r;
    for (int i = 0; i < 16; i++) r[32*i +: 32] = seed * (i + 3) ^ {i[7:0], 24'h5a3c1e} ^ (seed >> i);
    return r;
  endfunction

  // Driver: waits for an accepting cycle, launches, pushes the expectation.
  task automatic launch(input logic [STATE_W-1:0] s, input int r, input string tag);
    item_t it;
    int    n_even;
    @(negedge clk);
    while (busy) @(negedge clk);
    if (done) overlap++;
    n_even   = (r % (1 << CNT_W)) & ~1;
    state_in = s;
    rounds   = CNT_W'(r);
    start    = 1'b1;
    it.exp   = ref_block(s, n_even);
    it.lat   = n_even + 2;
    it.c0    = cyc;
    it.tag   = tag;
    sb_q.push_back(it);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: pops expectations on each completion; checks holding otherwise.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R8 spurious completion", "done=1", "no done");
        end else begin
          item_t it;
          it = sb_q.pop_front();
          chk(state_out == it.exp, it.tag, $sformatf("%h", state_out), $sformatf("%h", it.exp));
          chk((cyc - it.c0) == it.lat, {"R6 latency ", it.tag},
              $sformatf("%0d", cyc - it.c0), $sformatf("%0d", it.lat));
        end
        last_out = state_out;
      end else if (state_out !== last_out) begin
        chk(1'b0, "R9 output changed without done",
            $sformatf("%h", state_out), $sformatf("%h", last_out));
      end
    end
  end

  task automatic summary();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", "timeout", "finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0]        kin  [16];
    logic [31:0]        kout [16];
    logic [STATE_W-1:0] kvec, kres, s0;

    kin  = '{32'h61707865, 32'h3320646e, 32'h79622d32, 32'h6b206574,
             32'h03020100, 32'h07060504, 32'h0b0a0908, 32'h0f0e0d0c,
             32'h13121110, 32'h17161514, 32'h1b1a1918, 32'h1f1e1d1c,
             32'h00000001, 32'h09000000, 32'h4a000000, 32'h00000000};
    kout = '{32'he4e7f110, 32'h15593bd1, 32'h1fdd0f50, 32'hc47120a3,
             32'hc7f4d1c7, 32'h0368c033, 32'h9aaa2204, 32'h4e6cd4c3,
             32'h466482d2, 32'h09aa9f07, 32'h05d7c214, 32'ha2028bd9,
             32'hd19c12b5, 32'hb94e16de, 32'he883d0cb, 32'h4e3c50a2};
    for (int i = 0; i < 16; i++) begin
      kvec[32*i +: 32] = kin[i];
      kres[32*i +: 32] = kout[i];
    end

    repeat (4) @(negedge clk);
    // R10: reset state
    chk(busy == 1'b0 && done == 1'b0 && state_out == '0, "R10 reset outputs",
        $sformatf("busy=%b done=%b", busy, done), "all zero");
    rst_n = 1'b1;

    // R1 R2 R3: published 20-round vector
    launch(kvec, 20, "R2 R3 20-round vector");
    drain();
    chk(state_out == kres, "R1 R2 R3 known answer",
        $sformatf("%h", state_out), $sformatf("%h", kres));

    launch(pattern(32'h1234_5678), 8, "R2 8 rounds");
    launch(pattern(32'hdead_beef), 12, "R3 12 rounds");
    drain();

    // R5: zero rounds doubles each word
    s0 = pattern(32'h0bad_f00d);
    launch(s0, 0, "R5 zero rounds");
    drain();
    for (int i = 0; i < 16; i++)
      chk(state_out[32*i +: 32] == s0[32*i +: 32] + s0[32*i +: 32], "R5 word doubled",
          $sformatf("%h", state_out[32*i +: 32]), $sformatf("%h", s0[32*i +: 32] * 2));
    launch(pattern(32'h0000_0071), 1, "R5 one round as zero");

    // R4: odd counts round down
    launch(pattern(32'hcafe_0007), 7, "R4 seven as six");
    launch(pattern(32'hffff_ffff), 255, "R4 255 as 254");
    drain();

    // R8: start pulses while busy are ignored
    launch(pattern(32'h5555_aaaa), 12, "R8 run with ignored starts");
    for (int k = 0; k < 6; k++) begin
      state_in = pattern(32'h9999 + k);
      rounds   = CNT_W'(2);
      start    = 1'b1;
      @(negedge clk);
    end
    start = 1'b0;
    drain();
    repeat (20) @(negedge clk);
    chk(sb_q.size() == 0, "R8 no extra result", $sformatf("%0d", sb_q.size()), "0");

    // R11: back-to-back runs, each start lands on the previous done cycle
    overlap = 0;
    launch(pattern(32'h0101_0101), 4, "R11 first of chain");
    launch(pattern(32'h0202_0202), 0, "R11 zero-round middle");
    launch(pattern(32'h0303_0303), 2, "R11 last of chain");
    drain();
    chk(overlap == 2, "R11 start in done cycle", $sformatf("%0d", overlap), "2");

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule